// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control half of a 10-bit successive-approximation analog-to-digital converter. Everything runs on the oscillator clock. Two enable strobes are made from that clock, one after the other. A machine-rate strobe fires once every 4, 64 or 1024 oscillator cycles, chosen by a 2-bit divide code. A slower conversion strobe fires once every N+1 machine strobes, where N is a 4-bit prescale value. The conversion strobe steps the sequencer.

A start request arriving while the block is idle begins a conversion, which lasts exactly 16 conversion-clock periods. The sequencer first holds a sample control output high while the external sample-hold acquires the input. It then drives trial codes to an external DAC and reads back one comparator bit for each trial. It settles the result from bit 9 down to bit 0. Finally it publishes the 10-bit result and raises end-of-conversion. End-of-conversion then stays high until the next accepted start.

Top module: `sar_adc_sequencer`

## Requirements
- R1: After reset, `eoc_o`, `busy_o` and `sample_o` are 0, and `dac_code_o` and `result_o` are 0.
- R2: With an ideal comparator (`cmp_below_i` = 1 exactly when the input code is below `dac_code_o`), `result_o` after a conversion equals the input code, for any code from 0 to 1023.
- R3: Let T be the conversion-clock period in oscillator cycles. Count from the oscillator edge that accepts a start. `eoc_o` rises 15*T cycles later and `busy_o` falls 16*T cycles later.
- R4: The divide code selects the machine period: 00 gives 4 oscillator cycles, 01 gives 64, and both 10 and 11 give 1024.
- R5: The prescale value N (0 to 15) makes T equal to the machine period times N+1.
- R6: `sample_o` is high for the first 5*T cycles after an accepted start and low afterwards. `dac_code_o` is 0 while `sample_o` is high.
- R7: Trials run from bit 9 down to bit 0. A trial sets its bit to 1 on top of the bits already decided, with all lower bits 0, so the first trial code is 10'h200. A comparator value of 1 clears that bit on the next conversion strobe.
- R8: A start request made while `busy_o` is high is ignored. The timing and the result of the running conversion are unchanged.
- R9: `eoc_o` and `result_o` hold after a conversion until the next start is accepted. `eoc_o` is 0 in the cycle after that acceptance.
- R10: The divide code and the prescale value are captured when a start is accepted. Changing them during a conversion does not alter that conversion's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, accepted when idle |
| div_sel_i | input | 2 | Machine divide code (00: 4, 01: 64, 10/11: 1024) |
| prescale_i | input | 4 | Conversion prescale N, period multiplier N+1 |
| cmp_below_i | input | 1 | Comparator: 1 when the analog input is below the DAC level |
| dac_code_o | output | 10 | Trial code driven to the DAC |
| sample_o | output | 1 | Sample-hold acquire control |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | End of conversion, result valid |
| result_o | output | 10 | Converted code |

## Verification
The hardest situation to reach is a change that the block must not react to: a new divide and prescale setting, or a second start, arriving in the middle of a running conversion. The stimulus starts a short conversion and then, a few oscillator cycles later, raises the divide code to its slowest setting and the prescale value to its largest, or pulses start again. The edge counts at which the sample control falls, end-of-conversion rises and the block goes idle are measured. Each count must match the period captured at the original start, and the result must still equal the input code.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    DIV_SMALL = 2'b00,
    DIV_MID   = 2'b01,
    DIV_LARGE = 2'b10,
    DIV_ALIAS = 2'b11
  } div_sel_t;
endpackage

// File: rtl/machine_strobe_div.sv
module machine_strobe_div #(
  parameter int DIV_A = 4,
  parameter int DIV_B = 64,
  parameter int DIV_C = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  import sar_pkg::*;
  localparam int CW = $clog2(DIV_C);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    case (div_sel_t'(sel))
      DIV_SMALL: last = CW'(DIV_A - 1);
      DIV_MID:   last = CW'(DIV_B - 1);
      default:   last = CW'(DIV_C - 1);
    endcase
  end

  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run) cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/conv_prescaler.sv
module conv_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             mtick,
  input  logic [PRE_W-1:0] n,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = mtick && (cnt == n);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (mtick) cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W      = 10,
  parameter int SAMPLE_CYC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             ctick,
  input  logic             cmp_below,
  output logic             busy,
  output logic             sample,
  output logic             eoc,
  output logic [RES_W-1:0] sar,
  output logic [RES_W-1:0] result
);
  localparam int TOTAL  = SAMPLE_CYC + RES_W + 1;
  localparam int STEP_W = $clog2(TOTAL);

  logic [STEP_W-1:0] step;
  logic [RES_W-1:0]  next_sar;
  int                pos;
  logic              in_trial;

  always_comb begin
    in_trial = (int'(step) >= SAMPLE_CYC) && (int'(step) < SAMPLE_CYC + RES_W);
    pos      = RES_W - 1 - (int'(step) - SAMPLE_CYC);
    next_sar = sar;
    if (in_trial) begin
      if (cmp_below) next_sar[pos] = 1'b0;
      if (pos > 0) next_sar[pos-1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sample <= 1'b0;
      eoc    <= 1'b0;
      sar    <= '0;
      result <= '0;
      step   <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      sample <= 1'b1;
      eoc    <= 1'b0;
      sar    <= '0;
      step   <= '0;
    end else if (busy && ctick) begin
      step <= step + 1'b1;
      if (int'(step) == SAMPLE_CYC - 1) begin
        sample         <= 1'b0;
        sar            <= '0;
        sar[RES_W-1]   <= 1'b1;
      end else if (in_trial) begin
        sar <= next_sar;
        if (pos == 0) begin
          result <= next_sar;
          eoc    <= 1'b1;
        end
      end else if (int'(step) == TOTAL - 1) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_adc_sequencer.sv
module sar_adc_sequencer #(
  parameter int RES_W      = 10,
  parameter int PRE_W      = 4,
  parameter int SAMPLE_CYC = 5,
  parameter int DIV_A      = 4,
  parameter int DIV_B      = 64,
  parameter int DIV_C      = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       div_sel_i,
  input  logic [PRE_W-1:0] prescale_i,
  input  logic             cmp_below_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             eoc_o,
  output logic [RES_W-1:0] result_o
);
  logic             accept;
  logic [1:0]       div_q;
  logic [PRE_W-1:0] pre_q;
  logic             mtick;
  logic             ctick;

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (accept) begin
      div_q <= div_sel_i;
      pre_q <= prescale_i;
    end
  end

  machine_strobe_div #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_mdiv (
    .clk(clk), .rst(rst), .clear(accept), .run(busy_o), .sel(div_q), .tick(mtick)
  );

  conv_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clear(accept), .mtick(mtick), .n(pre_q), .tick(ctick)
  );

  sar_engine #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) u_eng (
    .clk(clk), .rst(rst), .accept(accept), .ctick(ctick), .cmp_below(cmp_below_i),
    .busy(busy_o), .sample(sample_o), .eoc(eoc_o), .sar(dac_code_o), .result(result_o)
  );
endmodule

// File: rtl/sar_adc_checker.sv
module sar_adc_checker #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             sample_o,
  input logic             busy_o,
  input logic             eoc_o,
  input logic [RES_W-1:0] dac_code_o,
  input logic [RES_W-1:0] result_o
);
  assert_accept_clears_eoc_R9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && !eoc_o && sample_o));

  assert_sample_within_busy_R6: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> busy_o);

  assert_dac_zero_sampling_R6: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> (dac_code_o == '0));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o && !eoc_o) |=> busy_o);

  assert_eoc_inside_busy_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_o) |-> (busy_o && !sample_o));

  assert_result_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !eoc_o |=> ($stable(result_o) || $rose(eoc_o)));
endmodule

bind sar_adc_sequencer sar_adc_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .sample_o(sample_o), .busy_o(busy_o),
  .eoc_o(eoc_o), .dac_code_o(dac_code_o), .result_o(result_o)
);

// File: tb/test_sar_adc_sequencer.sv
module test_sar_adc_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] div_sel_i = 2'b00;
  logic [3:0] prescale_i = 4'd0;
  logic       cmp_below_i;
  logic [9:0] dac_code_o;
  logic       sample_o;
  logic       busy_o;
  logic       eoc_o;
  logic [9:0] result_o;
  logic [9:0] vin = 10'd0;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  assign cmp_below_i = (vin < dac_code_o);

  sar_adc_sequencer i_sar_adc_sequencer (
    .clk(clk), .rst(rst), .start_i(start_i), .div_sel_i(div_sel_i),
    .prescale_i(prescale_i), .cmp_below_i(cmp_below_i), .dac_code_o(dac_code_o),
    .sample_o(sample_o), .busy_o(busy_o), .eoc_o(eoc_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mperiod(input logic [1:0] d);
    return (d == 2'b00) ? 4 : (d == 2'b01) ? 64 : 1024;
  endfunction

  // Runs one conversion; optional mid-run config change (R10) or extra start (R8).
  task automatic convert(input logic [9:0] code, input logic [1:0] d, input logic [3:0] n,
                         input bit midchange, input bit extra_start, input string tag);
    int t, k, ts, te, tb, dac_samp, dac_trial;
    t = mperiod(d) * (int'(n) + 1);
    vin = code;
    div_sel_i = d;
    prescale_i = n;
    ts = -1; te = -1; tb = -1; dac_samp = -1; dac_trial = -1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    check(busy_o && !eoc_o, {tag, " R9 accept clears eoc"}, int'(eoc_o), 0);
    while (busy_o && k < 150000) begin
      if (k == 1) begin
        dac_samp = int'(dac_code_o);
        if (midchange) begin
          div_sel_i = 2'b10;
          prescale_i = 4'd15;
        end
      end
      if (extra_start && k == 7) start_i = 1'b1;
      if (extra_start && k == 8) start_i = 1'b0;
      @(negedge clk);
      k++;
      if (ts < 0 && !sample_o) begin
        ts = k;
        dac_trial = int'(dac_code_o);
      end
      if (te < 0 && eoc_o) te = k;
    end
    tb = k;
    check(ts == 5 * t, {tag, " R6 sample length"}, ts, 5 * t);
    check(dac_samp == 0, {tag, " R6 dac zero while sampling"}, dac_samp, 0);
    check(dac_trial == 'h200, {tag, " R7 first trial code"}, dac_trial, 'h200);
    check(te == 15 * t, {tag, " R3 eoc timing"}, te, 15 * t);
    check(tb == 16 * t, {tag, " R3 busy length"}, tb, 16 * t);
    check(result_o == code, {tag, " R2 result"}, int'(result_o), int'(code));
  endtask

  task automatic t_reset();
    check(!eoc_o && !busy_o && !sample_o, "R1 control outputs", int'({eoc_o, busy_o, sample_o}), 0);
    check(dac_code_o == 0 && result_o == 0, "R1 data outputs", int'(result_o), 0);
  endtask

  task automatic t_timing_modes();
    convert(10'h2A5, 2'b00, 4'd0, 0, 0, "R4 div4 n0");
    convert(10'd0,   2'b00, 4'd3, 0, 0, "R5 div4 n3");
    convert(10'd1023, 2'b01, 4'd1, 0, 0, "R4 div64 n1");
    convert(10'd512, 2'b10, 4'd0, 0, 0, "R4 div1024");
    convert(10'd1,   2'b11, 4'd0, 0, 0, "R4 code11 alias");
    convert(10'd777, 2'b00, 4'd15, 0, 0, "R5 div4 n15");
  endtask

  task automatic t_midchange();
    convert(10'h155, 2'b00, 4'd2, 1, 0, "R10 config frozen");
  endtask

  task automatic t_start_ignored();
    convert(10'h3AA, 2'b00, 4'd1, 0, 1, "R8 start while busy");
  endtask

  task automatic t_eoc_hold();
    vin = 10'd0;
    repeat (40) @(negedge clk);
    check(eoc_o == 1'b1, "R9 eoc holds", int'(eoc_o), 1);
    check(result_o == 10'h3AA, "R9 result holds", int'(result_o), 'h3AA);
    check(!busy_o, "R9 idle while holding", int'(busy_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_timing_modes();
    t_midchange();
    t_start_ignored();
    t_eoc_hold();
    convert(10'd300, 2'b00, 4'd0, 0, 0, "R9 restart");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule